// File: doc/BRIEF.md
# CPU Halt and Wake Controller

This block governs the sleep state of a small 8-bit processor core. At every instruction boundary it looks at the retiring instruction's kind (halt, enable-interrupts, disable-interrupts or anything else), the master interrupt enable, a delayed-enable latch, and the 5-bit interrupt enable and flag vectors. From these it decides whether the core goes to sleep, when it wakes, and whether an interrupt is taken. When an interrupt is taken it also picks the return address.

The block reproduces two behaviours of the sleep instruction exactly. If the sleep instruction runs with interrupts masked while one is already pending, the core does not sleep. The next opcode fetch then fails to advance the program counter, so the byte after the sleep instruction is read twice. If the sleep instruction comes straight after an enable-interrupts instruction while an interrupt is pending, the interrupt is taken and the saved return address is the sleep instruction itself. The core returns into it and sleeps again.

The core supplies one-cycle strobes for instruction retirement and opcode fetch, together with the retiring instruction's own address and the address after it. Decode, the register file, memory and the vector priority encoder stay in the core.

Top module: `halt_wake_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, after that edge `low_power` is 0, `fetch_en` is 1, `ime_state` is 0, `irq_go` is 0, `pc_hold` is 0, and no delayed enable is waiting. A plain retirement after reset leaves `ime_state` at 0.
- R2: An interrupt is pending when at least one bit position is 1 in both `irq_enable` and `irq_flag`. Bits that are set in only one of the two vectors count as nothing pending.
- R3: A retirement with `op_ei` sets no master enable by itself. `ime_state` becomes 1 after the edge of the next retirement that is neither enable nor disable.
- R4: A retirement with `op_di` clears `ime_state` and cancels a waiting delayed enable.
- R5: A halt retirement with `ime_state`=1 and nothing pending raises `low_power` and lowers `fetch_en` after that edge. Both are released after the first edge at which an interrupt is pending. In that same cycle `irq_go` pulses and `irq_ret_addr` equals the halt's `next_addr`.
- R6: A halt retirement with master enable clear and nothing pending sleeps as in R5. It wakes on a pending interrupt without an `irq_go` pulse, and `ime_state` stays 0.
- R7: A halt retirement with master enable clear and an interrupt pending does not sleep. `pc_hold` is 1 during exactly the first later cycle with `fetch`=1 and 0 on all other cycles.
- R8: A halt retirement directly after an `op_ei` retirement, with an interrupt pending, does not sleep. It pulses `irq_go` after that edge with `irq_ret_addr` equal to the halt's own `op_addr`, and leaves `ime_state` at 0.
- R9: A non-halt retirement while the master enable is set, or becomes set by that retirement, and an interrupt is pending gives an `irq_go` pulse of exactly one cycle after the edge. `irq_ret_addr` then equals `next_addr` and `ime_state` is 0.
- R10: While `low_power` is 1, the `retire` and opcode inputs have no effect. An `op_ei` retirement during sleep leaves `ime_state` at 0 after the wake and after later plain retirements.
- R11: A halt retirement directly after an `op_ei` retirement with nothing pending sleeps with `ime_state`=1. On wake it pulses `irq_go` with `irq_ret_addr` equal to the halt's `next_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | An instruction completes this cycle |
| op_halt | input | 1 | The retiring instruction is the halt instruction |
| op_ei | input | 1 | The retiring instruction is enable-interrupts |
| op_di | input | 1 | The retiring instruction is disable-interrupts |
| op_addr | input | 16 | Address of the retiring instruction |
| next_addr | input | 16 | Address following the retiring instruction |
| fetch | input | 1 | Opcode fetch strobe from the core |
| irq_enable | input | 5 | Interrupt enable vector |
| irq_flag | input | 5 | Interrupt request flag vector |
| low_power | output | 1 | Core is asleep |
| fetch_en | output | 1 | Instruction fetch permitted |
| pc_hold | output | 1 | Do not advance the program counter on this fetch |
| ime_state | output | 1 | Current master interrupt enable |
| irq_go | output | 1 | One-cycle interrupt dispatch strobe |
| irq_ret_addr | output | 16 | Return address to push for the dispatch |

## Verification
The halt instruction is tried with each combination of master enable (set, clear, or about to be set by a directly preceding enable instruction) and of a pending interrupt at the moment it retires. This covers all four sleep outcomes: sleep-then-dispatch, sleep-then-resume, no sleep with a held program counter, and self-return dispatch. The pending decision is driven with enable and flag vectors that overlap on bit 0, bit 3 and bit 4, and with vectors that have bits set but do not overlap. This shows an AND of the two vectors rather than an OR or a single-vector test. The enable delay, its cancellation, dispatch at ordinary boundaries and instructions arriving during sleep are run against a behavioural model that is compared on every cycle.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } hwc_state_e;

    typedef enum logic [1:0] {
        RET_NEXT  = 2'd0,
        RET_SELF  = 2'd1,
        RET_SAVED = 2'd2
    } hwc_ret_e;

    typedef struct packed {
        logic     enter_sleep;
        logic     wake;
        logic     dispatch;
        hwc_ret_e ret_sel;
        logic     arm_hold;
        logic     ime_set;
        logic     ime_clr;
        logic     ew_set;
        logic     ew_clr;
    } hwc_action_t;

    function automatic logic any_pending(input logic [7:0] en, input logic [7:0] fl);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < 8; i++) begin
            hit = hit | (en[i] & fl[i]);
        end
        return hit;
    endfunction

endpackage

// File: rtl/hwc_decide.sv
module hwc_decide
    import hwc_pkg::*;
#(
    parameter int IRQ_N = 5
) (
    input  hwc_state_e       state,
    input  logic             ime,
    input  logic             ew,
    input  logic             retire,
    input  logic             op_halt,
    input  logic             op_ei,
    input  logic             op_di,
    input  logic [IRQ_N-1:0] irq_enable,
    input  logic [IRQ_N-1:0] irq_flag,
    output hwc_action_t      act
);

    localparam int PAD = 8 - IRQ_N;

    logic pend;
    logic ime_now;
    logic promoted;
    logic plain_halt;

    assign pend       = any_pending({{PAD{1'b0}}, irq_enable}, {{PAD{1'b0}}, irq_flag});
    assign plain_halt = op_halt & ~op_ei & ~op_di;

    always_comb begin
        act      = '0;
        ime_now  = ime;
        promoted = 1'b0;
        if (state == ST_SLEEP) begin
            if (pend) begin
                act.wake = 1'b1;
                if (ime) begin
                    act.dispatch = 1'b1;
                    act.ret_sel  = RET_SAVED;
                    act.ime_clr  = 1'b1;
                end
            end
        end else if (retire) begin
            if (op_di) begin
                act.ime_clr = 1'b1;
                act.ew_clr  = 1'b1;
                ime_now     = 1'b0;
            end else if (op_ei) begin
                act.ew_set = 1'b1;
            end else if (ew) begin
                act.ew_clr  = 1'b1;
                act.ime_set = 1'b1;
                ime_now     = 1'b1;
                promoted    = 1'b1;
            end

            if (plain_halt) begin
                if (promoted && pend) begin
                    act.dispatch = 1'b1;
                    act.ret_sel  = RET_SELF;
                    act.ime_clr  = 1'b1;
                end else if (ime_now && pend) begin
                    act.dispatch = 1'b1;
                    act.ret_sel  = RET_NEXT;
                    act.ime_clr  = 1'b1;
                end else if (ime_now) begin
                    act.enter_sleep = 1'b1;
                end else if (pend) begin
                    act.arm_hold = 1'b1;
                end else begin
                    act.enter_sleep = 1'b1;
                end
            end else if (ime_now && pend) begin
                act.dispatch = 1'b1;
                act.ret_sel  = RET_NEXT;
                act.ime_clr  = 1'b1;
                act.ew_clr   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hwc_enable_reg.sv
module hwc_enable_reg
    import hwc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  hwc_action_t act,
    output logic        ime,
    output logic        ew
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ime <= 1'b0;
            ew  <= 1'b0;
        end else begin
            if (act.ime_clr) begin
                ime <= 1'b0;
            end else if (act.ime_set) begin
                ime <= 1'b1;
            end
            if (act.ew_clr) begin
                ew <= 1'b0;
            end else if (act.ew_set) begin
                ew <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hwc_sleep_ctl.sv
module hwc_sleep_ctl
    import hwc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  hwc_action_t       act,
    input  logic              fetch,
    input  logic [ADDR_W-1:0] next_addr,
    output hwc_state_e        state,
    output logic [ADDR_W-1:0] saved_addr,
    output logic              hold_armed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            saved_addr <= '0;
            hold_armed <= 1'b0;
        end else begin
            if (act.enter_sleep) begin
                state      <= ST_SLEEP;
                saved_addr <= next_addr;
            end else if (act.wake) begin
                state <= ST_RUN;
            end
            if (act.arm_hold) begin
                hold_armed <= 1'b1;
            end else if (fetch) begin
                hold_armed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hwc_dispatch_out.sv
module hwc_dispatch_out
    import hwc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  hwc_action_t       act,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [ADDR_W-1:0] saved_addr,
    output logic              irq_go,
    output logic [ADDR_W-1:0] ret_addr
);

    logic [ADDR_W-1:0] ret_pick;

    always_comb begin
        case (act.ret_sel)
            RET_SELF:  ret_pick = op_addr;
            RET_SAVED: ret_pick = saved_addr;
            default:   ret_pick = next_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_go   <= 1'b0;
            ret_addr <= '0;
        end else begin
            irq_go <= act.dispatch;
            if (act.dispatch) begin
                ret_addr <= ret_pick;
            end
        end
    end

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hwc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IRQ_N  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              retire,
    input  logic              op_halt,
    input  logic              op_ei,
    input  logic              op_di,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              fetch,
    input  logic [IRQ_N-1:0]  irq_enable,
    input  logic [IRQ_N-1:0]  irq_flag,
    output logic              low_power,
    output logic              fetch_en,
    output logic              pc_hold,
    output logic              ime_state,
    output logic              irq_go,
    output logic [ADDR_W-1:0] irq_ret_addr
);

    hwc_action_t       act;
    hwc_state_e        state;
    logic              ime;
    logic              ew;
    logic              hold_armed;
    logic [ADDR_W-1:0] saved_addr;

    hwc_decide #(.IRQ_N(IRQ_N)) u_decide (
        .state      (state),
        .ime        (ime),
        .ew         (ew),
        .retire     (retire),
        .op_halt    (op_halt),
        .op_ei      (op_ei),
        .op_di      (op_di),
        .irq_enable (irq_enable),
        .irq_flag   (irq_flag),
        .act        (act)
    );

    hwc_enable_reg u_enable (
        .clk (clk),
        .rst (rst),
        .act (act),
        .ime (ime),
        .ew  (ew)
    );

    hwc_sleep_ctl #(.ADDR_W(ADDR_W)) u_sleep (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .fetch      (fetch),
        .next_addr  (next_addr),
        .state      (state),
        .saved_addr (saved_addr),
        .hold_armed (hold_armed)
    );

    hwc_dispatch_out #(.ADDR_W(ADDR_W)) u_disp (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .op_addr    (op_addr),
        .next_addr  (next_addr),
        .saved_addr (saved_addr),
        .irq_go     (irq_go),
        .ret_addr   (irq_ret_addr)
    );

    assign low_power = (state == ST_SLEEP);
    assign fetch_en  = (state == ST_RUN);
    assign pc_hold   = hold_armed & fetch;
    assign ime_state = ime;

endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
    parameter int IRQ_N = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             retire,
    input logic             op_halt,
    input logic             fetch,
    input logic [IRQ_N-1:0] irq_enable,
    input logic [IRQ_N-1:0] irq_flag,
    input logic             low_power,
    input logic             pc_hold,
    input logic             ime_state,
    input logic             irq_go
);

    // R5
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(low_power) |-> $past(retire && op_halt));

    // R5
    wake_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(low_power) |-> ($past(irq_enable & irq_flag) != '0));

    // R9
    go_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_go |=> !irq_go);

    // R9
    go_clears_ime_chk: assert property (@(posedge clk) disable iff (rst)
        irq_go |-> !ime_state);

    // R9
    go_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_go |-> $past(low_power || retire));

    // R7
    hold_on_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        pc_hold |-> fetch);

endmodule

bind halt_wake_ctrl hwc_checker #(.IRQ_N(IRQ_N)) u_hwc_checker (
    .clk        (clk),
    .rst        (rst),
    .retire     (retire),
    .op_halt    (op_halt),
    .fetch      (fetch),
    .irq_enable (irq_enable),
    .irq_flag   (irq_flag),
    .low_power  (low_power),
    .pc_hold    (pc_hold),
    .ime_state  (ime_state),
    .irq_go     (irq_go)
);

// File: tb/test_halt_wake_ctrl.sv
`timescale 1ns/1ps
module test_halt_wake_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire = 1'b0, op_halt = 1'b0, op_ei = 1'b0, op_di = 1'b0, fetch = 1'b0;
    logic [15:0] op_addr = '0, next_addr = '0;
    logic [4:0]  irq_enable = '0, irq_flag = '0;
    logic        low_power, fetch_en, pc_hold, ime_state, irq_go;
    logic [15:0] irq_ret_addr;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    finished = 1'b0;

    // behavioural reference state
    bit          m_sleep, m_ime, m_ew, m_hold, m_go;
    logic [15:0] m_ret, m_saved;

    always #4 clk = ~clk;

    halt_wake_ctrl i_halt_wake_ctrl (
        .clk(clk), .rst(rst), .retire(retire), .op_halt(op_halt), .op_ei(op_ei),
        .op_di(op_di), .op_addr(op_addr), .next_addr(next_addr), .fetch(fetch),
        .irq_enable(irq_enable), .irq_flag(irq_flag), .low_power(low_power),
        .fetch_en(fetch_en), .pc_hold(pc_hold), .ime_state(ime_state),
        .irq_go(irq_go), .irq_ret_addr(irq_ret_addr)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit pend;
        bit go;
        bit now_ime;
        bit raised;
        pend = (irq_enable & irq_flag) != 5'd0;
        go   = 1'b0;
        if (rst) begin
            m_sleep = 0; m_ime = 0; m_ew = 0; m_hold = 0; m_ret = 16'h0; m_saved = 16'h0;
            started = 1'b1;
        end else begin
            if (m_sleep) begin
                if (pend) begin
                    m_sleep = 0;
                    if (m_ime) begin
                        go = 1; m_ret = m_saved; m_ime = 0;
                    end
                end
            end else if (retire) begin
                raised = 0;
                if (op_di) begin
                    m_ime = 0; m_ew = 0;
                end else if (op_ei) begin
                    m_ew = 1;
                end else if (m_ew) begin
                    m_ew = 0; m_ime = 1; raised = 1;
                end
                now_ime = m_ime;
                if (op_halt && !op_ei && !op_di) begin
                    if (now_ime && pend) begin
                        go = 1; m_ime = 0;
                        m_ret = raised ? op_addr : next_addr;
                    end else if (!now_ime && pend) begin
                        m_hold = 1;
                    end else begin
                        m_sleep = 1; m_saved = next_addr;
                    end
                end else if (now_ime && pend) begin
                    go = 1; m_ime = 0; m_ew = 0; m_ret = next_addr;
                end
            end
            if (!(retire && op_halt && !m_sleep && m_hold && !fetch) && fetch && !(m_hold && !m_sleep && retire && op_halt))
                m_hold = 0;
        end
        m_go = go;
    end

    always @(negedge clk) begin
        if (started && !rst && !finished) begin
            check(cur_req, low_power, m_sleep, "model low_power");
            check(cur_req, fetch_en, !m_sleep, "model fetch_en");
            check(cur_req, ime_state, m_ime, "model ime_state");
            check(cur_req, irq_go, m_go, "model irq_go");
            check(cur_req, pc_hold, m_hold & fetch, "model pc_hold");
            check(cur_req, irq_ret_addr, m_ret, "model irq_ret_addr");
        end
    end

    task automatic drive(input bit r, input bit h, input bit e, input bit d, input bit f,
                         input logic [15:0] oa, input logic [15:0] na);
        @(posedge clk);
        #2;
        retire = r; op_halt = h; op_ei = e; op_di = d; fetch = f;
        op_addr = oa; next_addr = na;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 16'h0, 16'h0);
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        look();
        check("R1", low_power, 0, "low_power after reset");
        check("R1", fetch_en, 1, "fetch_en after reset");
        check("R1", ime_state, 0, "ime after reset");
        check("R1", irq_go, 0, "irq_go after reset");
        drive(1, 0, 0, 0, 0, 16'h0010, 16'h0011);
        idle(1); look();
        check("R1", ime_state, 0, "no delayed enable after reset");

        // R2 + R6: non-overlapping bits, master enable clear -> sleep
        cur_req = "R6";
        irq_enable = 5'b00100; irq_flag = 5'b00010;
        drive(1, 1, 0, 0, 0, 16'h0100, 16'h0101);
        idle(1); look();
        check("R2", low_power, 1, "no overlap means nothing pending");
        check("R6", fetch_en, 0, "fetch gated in sleep");
        // R10: enable instruction while asleep is ignored
        cur_req = "R10";
        drive(1, 0, 1, 0, 0, 16'h0102, 16'h0103);
        idle(2);
        irq_flag = 5'b00110;
        idle(1); look();
        check("R6", low_power, 0, "woke on overlap");
        check("R6", irq_go, 0, "no dispatch when enable clear");
        irq_flag = 5'b00000;
        drive(1, 0, 0, 0, 0, 16'h0101, 16'h0102);
        drive(1, 0, 0, 0, 0, 16'h0102, 16'h0103);
        idle(1); look();
        check("R10", ime_state, 0, "ei during sleep had no effect");

        // R7: masked halt with pending interrupt
        cur_req = "R7";
        irq_enable = 5'b01000; irq_flag = 5'b01000;
        drive(1, 1, 0, 0, 0, 16'h0200, 16'h0201);
        idle(2); look();
        check("R7", low_power, 0, "no sleep when pending and masked");
        check("R7", pc_hold, 0, "no hold without fetch");
        drive(0, 0, 0, 0, 1, 16'h0, 16'h0);
        look();
        check("R7", pc_hold, 1, "hold on first fetch");
        drive(0, 0, 0, 0, 1, 16'h0, 16'h0);
        look();
        check("R7", pc_hold, 0, "hold is one-shot");
        idle(1);
        irq_flag = 5'b00000;

        // R3: delayed enable
        cur_req = "R3";
        drive(1, 0, 1, 0, 0, 16'h0300, 16'h0301);
        idle(1); look();
        check("R3", ime_state, 0, "ei alone does not enable");
        drive(1, 0, 0, 0, 0, 16'h0301, 16'h0302);
        idle(1); look();
        check("R3", ime_state, 1, "enabled after next instruction");

        // R9: dispatch at boundary, bit 0
        cur_req = "R9";
        irq_enable = 5'b00001; irq_flag = 5'b00001;
        drive(1, 0, 0, 0, 0, 16'h1233, 16'h1234);
        idle(1); look();
        check("R9", irq_go, 1, "dispatch strobe");
        check("R9", irq_ret_addr, 16'h1234, "return to next");
        check("R9", ime_state, 0, "enable cleared by dispatch");
        idle(1); look();
        check("R9", irq_go, 0, "strobe lasts one cycle");
        irq_flag = 5'b00000;

        // R4: disable cancels delayed and active enable
        cur_req = "R4";
        drive(1, 0, 1, 0, 0, 16'h0400, 16'h0401);
        drive(1, 0, 0, 1, 0, 16'h0401, 16'h0402);
        drive(1, 0, 0, 0, 0, 16'h0402, 16'h0403);
        idle(1); look();
        check("R4", ime_state, 0, "delayed enable cancelled");
        drive(1, 0, 1, 0, 0, 16'h0403, 16'h0404);
        drive(1, 0, 0, 0, 0, 16'h0404, 16'h0405);
        drive(1, 0, 0, 1, 0, 16'h0405, 16'h0406);
        idle(1); look();
        check("R4", ime_state, 0, "active enable cleared");

        // R5: enabled halt, nothing pending, wake on bit 4
        cur_req = "R5";
        irq_enable = 5'b10001; irq_flag = 5'b00000;
        drive(1, 0, 1, 0, 0, 16'h04FF, 16'h0500);
        drive(1, 0, 0, 0, 0, 16'h0500, 16'h0501);
        drive(1, 1, 0, 0, 0, 16'h0600, 16'h0601);
        idle(3); look();
        check("R5", low_power, 1, "sleeping with enable set");
        check("R5", ime_state, 1, "enable kept while asleep");
        irq_flag = 5'b10000;
        idle(1); look();
        check("R5", low_power, 0, "released after pending");
        check("R5", irq_go, 1, "dispatch on wake");
        check("R5", irq_ret_addr, 16'h0601, "return after halt");
        irq_flag = 5'b00000;
        idle(1);

        // R8: ei then halt with pending interrupt
        cur_req = "R8";
        irq_enable = 5'b00001; irq_flag = 5'b00001;
        drive(1, 0, 1, 0, 0, 16'h06FF, 16'h0700);
        drive(1, 1, 0, 0, 0, 16'h0700, 16'h0701);
        idle(1); look();
        check("R8", irq_go, 1, "dispatch after ei-halt");
        check("R8", irq_ret_addr, 16'h0700, "return into halt");
        check("R8", low_power, 0, "no sleep");
        check("R8", ime_state, 0, "enable cleared");
        irq_flag = 5'b00000;
        idle(1);

        // R11: ei then halt with nothing pending
        cur_req = "R11";
        drive(1, 0, 1, 0, 0, 16'h07FF, 16'h0800);
        drive(1, 1, 0, 0, 0, 16'h0800, 16'h0801);
        idle(2); look();
        check("R11", low_power, 1, "sleeps");
        check("R11", ime_state, 1, "enable now set");
        irq_flag = 5'b00001;
        idle(1); look();
        check("R11", irq_go, 1, "dispatch on wake");
        check("R11", irq_ret_addr, 16'h0801, "return after halt");
        irq_flag = 5'b00000;
        idle(3);
        finish_run();
    end

endmodule